// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This engine carries out the data movement of a four-channel DMA controller. Each channel presents a packed mode byte, a mask bit, a base address and a base count. The engine holds each channel's current address, current count, pending element count and two status flags. A request pulse on a channel arms it with a requested length. The engine then grants one channel per cycle in fixed priority order. For each granted element it issues one memory cycle at the channel's current address and pulses that channel's acknowledge.

After every element the current address steps up or down by the element size and the current count drops by one. When the count runs out, the channel's terminal-count flag is set and its software-request flag is cleared. If the mode byte enables it, the current registers are also reloaded from the base registers. The operating mode decides whether a channel gives up the engine after each element or keeps it until its request is done. A companion register block programs the base values and loads them into the current registers through a per-channel load strobe.

Top module: `dmae_engine`

## Requirements
- R1: While reset is held and just after it, every output is zero: acknowledges, strobes, memory address, both flag vectors, and all current addresses and counts.
- R2: A channel whose mask bit is 1 gets no acknowledge and no strobe. Its pending request is kept and runs once the mask bit returns to 0.
- R3: A request of length L on a channel whose current count is N moves exactly min(L, N) elements. L = 0 or N = 0 moves none.
- R4: Mode bits [3:2] select the transfer type. 01 writes memory (mem_wr_o), 10 reads memory (mem_rd_o), and 00 verifies: an acknowledge with neither strobe. 11 discards the request and leaves address and count untouched.
- R5: Each element steps the current address by ELEM_BYTES, downward when mode bit 5 is 1 and upward otherwise. The current count drops by one. mem_addr_o shows the address from before the step.
- R6: The element that brings the current count to zero sets that channel's tc_o bit, clears its soft_o bit and ends its request.
- R7: With mode bit 4 set, that same element reloads the current address and count from the base inputs instead of leaving the stepped values.
- R8: Among eligible channels, the lowest index wins. Mode bits [7:6] = 01 (single) re-arbitrates after every element. 10 (block) and 00 (demand) keep the engine until the request ends.
- R9: In demand mode (bits [7:6] = 00), the pending request is discarded when req_hold_i for that channel is 0 at a clock edge. This holds even before terminal count.
- R10: Mode bits [7:6] = 11 (cascade) perform no transfer and discard the request.
- R11: ld_cur_i copies base into current and clears tc_o. sw_req_i sets soft_o and wins over a terminal-count clear in the same cycle.
- R12: req_go_i on a channel that is already transferring replaces its remaining length with the new one.
- R13: All outputs are registered. The acknowledge and strobe for an element appear one cycle after the edge that selects it, as pulses one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | NCH*8 | Packed mode byte per channel |
| mask_i | input | NCH | Per-channel mask |
| base_addr_i | input | NCH*AW | Base address per channel |
| base_cnt_i | input | NCH*CW | Base element count per channel |
| ld_cur_i | input | NCH | Load current registers from base, clear tc |
| req_go_i | input | NCH | Request pulse, arms the channel with req_len_i |
| req_len_i | input | NCH*LW | Requested element count per channel |
| req_hold_i | input | NCH | Request level, watched in demand mode |
| sw_req_i | input | NCH | Sets the software-request flag |
| mem_addr_o | output | AW | Address of the current element |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| dack_o | output | NCH | One-hot element acknowledge |
| tc_o | output | NCH | Terminal-count flags |
| soft_o | output | NCH | Software-request flags |
| cur_addr_o | output | NCH*AW | Current address per channel |
| cur_cnt_o | output | NCH*CW | Current count per channel |

## Verification
Terminal count and a software request can fall on the same channel in the same cycle. The terminal-count element tries to clear soft_o while sw_req_i tries to set it. The bench provokes this by timing sw_req_i to land on the edge of a channel's final element, then expects both tc_o and soft_o set. A request pulse that lands on an element cycle of the same channel is also provoked, and is judged by the total number of acknowledges. Random stimulus mixes both collisions with reloads and mask changes against a cycle model.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

  typedef enum logic [1:0] {
    OP_DEMAND  = 2'b00,
    OP_SINGLE  = 2'b01,
    OP_BLOCK   = 2'b10,
    OP_CASCADE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    XF_VERIFY  = 2'b00,
    XF_TOMEM   = 2'b01,
    XF_FROMMEM = 2'b10,
    XF_BAD     = 2'b11
  } xf_e;

  typedef struct packed {
    op_e  op;
    logic dec;
    logic autoinit;
    xf_e  xf;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] b);
    mode_t m;
    m.op       = op_e'(b[7:6]);
    m.dec      = b[5];
    m.autoinit = b[4];
    m.xf       = xf_e'(b[3:2]);
    return m;
  endfunction

endpackage

// File: rtl/dmae_decode.sv
module dmae_decode
  import dmae_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*8-1:0]      mode_i,
  output dmae_pkg::mode_t [NCH-1:0] md_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign md_o[g] = decode_mode(mode_i[g*8 +: 8]);
  end

endmodule

// File: rtl/dmae_arb.sv
module dmae_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] elig_i,
  input  logic           lock_vld_i,
  input  logic [CHW-1:0] lock_ch_i,
  output logic           sel_vld_o,
  output logic [CHW-1:0] sel_ch_o
);

  always_comb begin
    sel_vld_o = 1'b0;
    sel_ch_o  = '0;
    if (lock_vld_i && elig_i[lock_ch_i]) begin
      sel_vld_o = 1'b1;
      sel_ch_o  = lock_ch_i;
    end else begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (elig_i[c]) begin
          sel_vld_o = 1'b1;
          sel_ch_o  = CHW'(c);
        end
      end
    end
  end

endmodule

// File: rtl/dmae_chan.sv
module dmae_chan #(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int LW         = 8,
  parameter int ELEM_BYTES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          go_i,
  input  logic [LW-1:0] len_i,
  input  logic          sw_i,
  input  logic          step_i,
  input  logic          drop_i,
  input  logic          dec_i,
  input  logic          auto_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic [LW-1:0] pend_o,
  output logic          tc_o,
  output logic          soft_o,
  output logic          last_o
);

  localparam logic [AW-1:0] STEP = AW'(ELEM_BYTES);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] pend_q, pend_d;
  logic          tc_q, tc_d, soft_q, soft_d;
  logic          final_el;

  assign final_el = (cnt_q == CW'(1));
  assign last_o   = final_el || (pend_q == LW'(1));

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    tc_d   = tc_q;
    soft_d = soft_q;
    if (drop_i) pend_d = '0;
    if (step_i) begin
      addr_d = dec_i ? addr_q - STEP : addr_q + STEP;
      cnt_d  = cnt_q - CW'(1);
      pend_d = pend_q - LW'(1);
      if (final_el) begin
        tc_d   = 1'b1;
        soft_d = 1'b0;
        pend_d = '0;
        if (auto_i) begin
          addr_d = base_addr_i;
          cnt_d  = base_cnt_i;
        end
      end
    end
    if (go_i) pend_d = len_i;
    if (sw_i) soft_d = 1'b1;
    if (ld_i) begin
      addr_d = base_addr_i;
      cnt_d  = base_cnt_i;
      tc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      tc_q   <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      tc_q   <= tc_d;
      soft_q <= soft_d;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
  assign tc_o   = tc_q;
  assign soft_o = soft_q;

endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
  import dmae_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int LW         = 8,
  parameter int ELEM_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*8-1:0]  mode_i,
  input  logic [NCH-1:0]    mask_i,
  input  logic [NCH*AW-1:0] base_addr_i,
  input  logic [NCH*CW-1:0] base_cnt_i,
  input  logic [NCH-1:0]    ld_cur_i,
  input  logic [NCH-1:0]    req_go_i,
  input  logic [NCH*LW-1:0] req_len_i,
  input  logic [NCH-1:0]    req_hold_i,
  input  logic [NCH-1:0]    sw_req_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [NCH-1:0]    dack_o,
  output logic [NCH-1:0]    tc_o,
  output logic [NCH-1:0]    soft_o,
  output logic [NCH*AW-1:0] cur_addr_o,
  output logic [NCH*CW-1:0] cur_cnt_o
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  mode_t [NCH-1:0] md;
  logic [AW-1:0]   addr_a [NCH];
  logic [CW-1:0]   cnt_a  [NCH];
  logic [LW-1:0]   pend_a [NCH];
  logic [NCH-1:0]  last_v, elig_v, drop_v;

  logic            sel_vld;
  logic [CHW-1:0]  sel_ch;
  mode_t           sm;

  logic            lock_vld_q, lock_vld_d;
  logic [CHW-1:0]  lock_ch_q, lock_ch_d;
  logic [AW-1:0]   maddr_q, maddr_d;
  logic            rd_q, rd_d, wr_q, wr_d;
  logic [NCH-1:0]  dack_q, dack_d;

  dmae_decode #(.NCH(NCH)) u_dec (
    .mode_i (mode_i),
    .md_o   (md)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign drop_v[g] = (pend_a[g] != '0) &&
                       (md[g].op == OP_CASCADE || md[g].xf == XF_BAD ||
                        cnt_a[g] == '0 ||
                        (md[g].op == OP_DEMAND && !req_hold_i[g]));
    assign elig_v[g] = (pend_a[g] != '0) && !mask_i[g] && !drop_v[g];

    dmae_chan #(
      .AW(AW), .CW(CW), .LW(LW), .ELEM_BYTES(ELEM_BYTES)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_i        (ld_cur_i[g]),
      .go_i        (req_go_i[g]),
      .len_i       (req_len_i[g*LW +: LW]),
      .sw_i        (sw_req_i[g]),
      .step_i      (sel_vld && (sel_ch == CHW'(g))),
      .drop_i      (drop_v[g]),
      .dec_i       (md[g].dec),
      .auto_i      (md[g].autoinit),
      .base_addr_i (base_addr_i[g*AW +: AW]),
      .base_cnt_i  (base_cnt_i[g*CW +: CW]),
      .addr_o      (addr_a[g]),
      .cnt_o       (cnt_a[g]),
      .pend_o      (pend_a[g]),
      .tc_o        (tc_o[g]),
      .soft_o      (soft_o[g]),
      .last_o      (last_v[g])
    );

    assign cur_addr_o[g*AW +: AW] = addr_a[g];
    assign cur_cnt_o[g*CW +: CW]  = cnt_a[g];
  end

  dmae_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .elig_i     (elig_v),
    .lock_vld_i (lock_vld_q),
    .lock_ch_i  (lock_ch_q),
    .sel_vld_o  (sel_vld),
    .sel_ch_o   (sel_ch)
  );

  assign sm = md[sel_ch];

  always_comb begin
    lock_vld_d = 1'b0;
    lock_ch_d  = lock_ch_q;
    maddr_d    = maddr_q;
    rd_d       = 1'b0;
    wr_d       = 1'b0;
    dack_d     = '0;
    if (sel_vld) begin
      lock_vld_d = (sm.op == OP_BLOCK || sm.op == OP_DEMAND) && !last_v[sel_ch];
      lock_ch_d  = sel_ch;
      maddr_d    = addr_a[sel_ch];
      rd_d       = (sm.xf == XF_FROMMEM);
      wr_d       = (sm.xf == XF_TOMEM);
      dack_d     = NCH'(1) << sel_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_vld_q <= 1'b0;
      lock_ch_q  <= '0;
      maddr_q    <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      dack_q     <= '0;
    end else begin
      lock_vld_q <= lock_vld_d;
      lock_ch_q  <= lock_ch_d;
      if (sel_vld) maddr_q <= maddr_d;
      rd_q       <= rd_d;
      wr_q       <= wr_d;
      dack_q     <= dack_d;
    end
  end

  assign mem_addr_o = maddr_q;
  assign mem_rd_o   = rd_q;
  assign mem_wr_o   = wr_q;
  assign dack_o     = dack_q;

endmodule

// File: rtl/dmae_engine_chk.sv
module dmae_engine_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH*8-1:0] mode_i,
  input logic [NCH-1:0]   mask_i,
  input logic [NCH-1:0]   dack_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic [NCH-1:0]   tc_o
);

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R4

  AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (dack_o != '0)); // R13

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i[g] |=> !dack_o[g]); // R2

    AST_CASCADE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[g*8+7 -: 2] == 2'b11) |=> !dack_o[g]); // R10

    AST_BADTYPE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[g*8+3 -: 2] == 2'b11) |=> !dack_o[g]); // R4

    AST_TC_ON_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_o[g]) |-> dack_o[g]); // R6
  end

endmodule

bind dmae_engine dmae_engine_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .mask_i   (mask_i),
  .dack_o   (dack_o),
  .mem_rd_o (mem_rd_o),
  .mem_wr_o (mem_wr_o),
  .tc_o     (tc_o)
);

// File: tb/sim_dmae_engine.sv
`timescale 1ns/1ps
module sim_dmae_engine;

  localparam int NCH = 4, AW = 16, CW = 16, LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]  mode_r;
  logic [3:0]   mask_r, ld_r, go_r, hold_r, sw_r;
  logic [63:0]  base_addr_r, base_cnt_r;
  logic [31:0]  len_r;
  logic [15:0]  mem_addr_o;
  logic         mem_rd_o, mem_wr_o;
  logic [3:0]   dack_o, tc_o, soft_o;
  logic [63:0]  cur_addr_o, cur_cnt_o;

  dmae_engine u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_r), .mask_i(mask_r),
    .base_addr_i(base_addr_r), .base_cnt_i(base_cnt_r), .ld_cur_i(ld_r),
    .req_go_i(go_r), .req_len_i(len_r), .req_hold_i(hold_r), .sw_req_i(sw_r),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .dack_o(dack_o), .tc_o(tc_o), .soft_o(soft_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- cycle model built from the requirements ----------------
  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [7:0]  m_pend [4];
  logic [3:0]  m_tc, m_soft, e_dack, el, dr;
  logic        e_rd, e_wr, m_lv;
  logic [15:0] e_addr;
  int          m_lc, s;
  logic [1:0]  op, xf;
  logic        lastf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_addr[c] = '0; m_cnt[c] = '0; m_pend[c] = '0;
      end
      m_tc = '0; m_soft = '0; e_dack = '0; e_rd = 0; e_wr = 0;
      e_addr = '0; m_lv = 0; m_lc = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        op = mode_r[c*8+7 -: 2];
        xf = mode_r[c*8+3 -: 2];
        dr[c] = (m_pend[c] != 0) && (op == 2'b11 || xf == 2'b11 ||
                m_cnt[c] == 0 || (op == 2'b00 && !hold_r[c]));
        el[c] = (m_pend[c] != 0) && !mask_r[c] && !dr[c];
      end
      s = -1;
      if (m_lv && el[m_lc]) s = m_lc;
      else for (int c = 3; c >= 0; c--) if (el[c]) s = c;
      e_dack = '0; e_rd = 0; e_wr = 0;
      if (s >= 0) begin
        op = mode_r[s*8+7 -: 2];
        xf = mode_r[s*8+3 -: 2];
        e_dack[s] = 1'b1;
        e_rd = (xf == 2'b10);
        e_wr = (xf == 2'b01);
        e_addr = m_addr[s];
        lastf = (m_pend[s] == 1) || (m_cnt[s] == 1);
        m_lv = (op == 2'b00 || op == 2'b10) && !lastf;
        m_lc = s;
      end else m_lv = 0;
      for (int c = 0; c < 4; c++) begin
        if (dr[c]) m_pend[c] = '0;
        if (s == c) begin
          if (m_cnt[c] == 1) begin
            m_tc[c] = 1; m_soft[c] = 0; m_pend[c] = 0;
            if (mode_r[c*8+4]) begin
              m_addr[c] = base_addr_r[c*16 +: 16];
              m_cnt[c]  = base_cnt_r[c*16 +: 16];
            end else begin
              m_addr[c] = mode_r[c*8+5] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
              m_cnt[c]  = 0;
            end
          end else begin
            m_addr[c] = mode_r[c*8+5] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
            m_cnt[c]  = m_cnt[c] - 16'd1;
            m_pend[c] = m_pend[c] - 8'd1;
          end
        end
        if (go_r[c]) m_pend[c] = len_r[c*8 +: 8];
        if (sw_r[c]) m_soft[c] = 1;
        if (ld_r[c]) begin
          m_addr[c] = base_addr_r[c*16 +: 16];
          m_cnt[c]  = base_cnt_r[c*16 +: 16];
          m_tc[c]   = 0;
        end
      end
    end
  end

  logic run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R8 dack", dack_o, e_dack);
      chk("R4 mem_rd", mem_rd_o, e_rd);
      chk("R4 mem_wr", mem_wr_o, e_wr);
      chk("R5 mem_addr", mem_addr_o, e_addr);
      chk("R6 tc", tc_o, m_tc);
      chk("R11 soft", soft_o, m_soft);
      for (int c = 0; c < 4; c++) begin
        chk("R5 cur_addr", cur_addr_o[c*16 +: 16], m_addr[c]);
        chk("R3 cur_cnt", cur_cnt_o[c*16 +: 16], m_cnt[c]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  int dcnt [4];
  int strb;
  int seq [16];
  int nseq;

  task automatic clr_stats();
    for (int c = 0; c < 4; c++) dcnt[c] = 0;
    strb = 0; nseq = 0;
  endtask

  task automatic step_cyc();
    @(negedge clk);
    for (int c = 0; c < 4; c++) if (dack_o[c]) begin
      dcnt[c]++;
      if (nseq < 16) begin seq[nseq] = c; nseq++; end
    end
    if (mem_rd_o || mem_wr_o) strb++;
    ld_r = '0; go_r = '0; sw_r = '0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step_cyc();
  endtask

  task automatic setup(input int c, input logic [7:0] md, input logic [15:0] ba, input logic [15:0] bc);
    mode_r[c*8 +: 8] = md;
    base_addr_r[c*16 +: 16] = ba;
    base_cnt_r[c*16 +: 16] = bc;
    ld_r[c] = 1'b1;
    step_cyc();
  endtask

  task automatic go(input int c, input logic [7:0] l);
    go_r[c] = 1'b1;
    len_r[c*8 +: 8] = l;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    mode_r = {4{8'h40}}; mask_r = '0; ld_r = '0; go_r = '0; hold_r = '1; sw_r = '0;
    base_addr_r = '0; base_cnt_r = '0; len_r = '0;
    repeat (3) @(negedge clk);
    chk("R1 dack in reset", dack_o, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tc", tc_o, 4'h0);
    chk("R1 soft", soft_o, 4'h0);
    chk("R1 strobes", {mem_rd_o, mem_wr_o}, 2'b00);
    chk("R1 cur", {cur_addr_o, cur_cnt_o}, 128'h0);
    run_cmp = 1;

    // R3 R6 R13: single write, length 5 on count 3
    setup(1, 8'h44, 16'h0100, 16'd3);
    clr_stats(); go(1, 8'd5); steps(8);
    chk("R3 elements min(len,cnt)", dcnt[1], 3);
    chk("R4 write strobes", strb, 3);
    chk("R6 tc set", tc_o[1], 1'b1);
    chk("R5 addr after", cur_addr_o[16 +: 16], 16'h0103);

    // R7 R5: block, decrement, autoinit, read
    setup(2, 8'hB8, 16'h0200, 16'd2);
    clr_stats(); go(2, 8'd2); steps(6);
    chk("R7 reload addr", cur_addr_o[32 +: 16], 16'h0200);
    chk("R7 reload cnt", cur_cnt_o[32 +: 16], 16'd2);
    chk("R4 read strobes", strb, 2);

    // R2 masked channel keeps request
    mask_r[0] = 1'b1;
    setup(0, 8'h44, 16'h0010, 16'd4);
    clr_stats(); go(0, 8'd2); steps(6);
    chk("R2 masked no ack", dcnt[0], 0);
    mask_r[0] = 1'b0; steps(6);
    chk("R2 resumed", dcnt[0], 2);
    chk("R2 cnt", cur_cnt_o[0 +: 16], 16'd2);

    // R4 illegal type, then verify
    setup(3, 8'h4C, 16'h0030, 16'd3);
    clr_stats(); go(3, 8'd2); steps(5);
    mode_r[31:24] = 8'h40; steps(4);
    chk("R4 illegal discards", dcnt[3], 0);
    chk("R4 illegal cnt kept", cur_cnt_o[48 +: 16], 16'd3);
    go(3, 8'd2); steps(5);
    chk("R4 verify acks", dcnt[3], 2);
    chk("R4 verify no strobe", strb, 0);

    // R10 cascade
    mode_r[31:24] = 8'hC4;
    clr_stats(); go(3, 8'd2); steps(5);
    chk("R10 cascade idle", dcnt[3], 0);

    // R9 demand stop
    setup(1, 8'h04, 16'h0100, 16'd10);
    clr_stats(); go(1, 8'd8); steps(3);
    hold_r[1] = 1'b0; steps(3); hold_r[1] = 1'b1; steps(6);
    chk("R9 demand stopped", dcnt[1], 2);
    chk("R9 cnt", cur_cnt_o[16 +: 16], 16'd8);

    // R8 fixed priority, single then block lock
    setup(0, 8'h44, 16'h0040, 16'd9);
    setup(2, 8'h48, 16'h0080, 16'd9);
    clr_stats(); go(0, 8'd2); go(2, 8'd2); steps(7);
    chk("R8 order single", {seq[0][1:0], seq[1][1:0], seq[2][1:0], seq[3][1:0]}, 8'b00_00_10_10);
    mode_r[23:16] = 8'h88;
    clr_stats(); go(2, 8'd3); steps(2);
    go(0, 8'd1); steps(6);
    chk("R8 block holds", {seq[0][1:0], seq[1][1:0], seq[2][1:0], seq[3][1:0]}, 8'b10_10_10_00);

    // R12 new request during transfer
    setup(0, 8'h44, 16'h0000, 16'd20);
    clr_stats(); go(0, 8'd5); steps(2);
    go(0, 8'd1); steps(6);
    chk("R12 length replaced", dcnt[0], 3);

    // R11 software flag, and its collision with terminal count
    sw_r[3] = 1'b1; step_cyc();
    chk("R11 soft set", soft_o[3], 1'b1);
    setup(3, 8'h40, 16'h0030, 16'd1);
    chk("R11 ld clears tc", tc_o[3], 1'b0);
    go(3, 8'd1); steps(4);
    chk("R6 soft cleared at tc", soft_o[3], 1'b0);
    setup(3, 8'h40, 16'h0030, 16'd2);
    go(3, 8'd2); steps(2);
    sw_r[3] = 1'b1; steps(3);
    chk("R11 sw wins over tc", {tc_o[3], soft_o[3]}, 2'b11);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 4; c++) begin
        if ($urandom_range(0, 15) == 0) mode_r[c*8 +: 8] = 8'($urandom);
        if ($urandom_range(0, 19) == 0) mask_r[c] = ($urandom_range(0, 3) == 0);
        hold_r[c] = ($urandom_range(0, 7) != 0);
        if ($urandom_range(0, 11) == 0) begin
          base_addr_r[c*16 +: 16] = 16'($urandom);
          base_cnt_r[c*16 +: 16]  = 16'($urandom_range(0, 6));
          ld_r[c] = 1'b1;
        end
        if ($urandom_range(0, 7) == 0) begin
          go_r[c] = 1'b1;
          len_r[c*8 +: 8] = 8'($urandom_range(0, 7));
        end
        sw_r[c] = ($urandom_range(0, 15) == 0);
      end
      step_cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule